// File: doc/BRIEF.md
# Multi-domain sleep and wake sequencer

This block controls power for a chip split into three domains: an always-on domain that is never switched, a system domain, and a core domain that holds two processor clusters, a network core and an application core. A sleep request carries a target (sleep or deep-sleep) and, for each cluster, a choice between gating only its clock and removing its power. The sequencer walks each switched domain through its clock-enable, isolation, reset and power-enable outputs one step at a time. A programmable settle delay separates consecutive steps.

Entry is refused while the wakelock input is held. A deep-sleep request is honoured only when the deep lock is also released. That lock is a register that comes out of reset held; otherwise the request is carried out as ordinary sleep. While the system is asleep, a bank of masked wakeup inputs brings the domains back in reverse order. After a full entry it first waits a parameterised oscillator start-up time. At the end it pulses a wake interrupt to the core each triggering source is routed to. A wake event that arrives during entry turns the sequence around at once, from the step it had reached.

Top module: `pwr_seq_top`

## Requirements
- R1: Out of reset all three switched domains are on: clkEn=111, isoEn=000, rstAct=000, pwrEn=111, busy=0, mode=0 (0 run, 1 sleep, 2 deep-sleep), wakeCause=0. Bit index 0 is the application core, 1 the network core, 2 the system domain.
- R2: A sleep request made while wakeLockHeld=1 is ignored; busy stays 0 and all domain outputs stay on.
- R3: A deep-sleep request while the deep lock is held (its reset state, or after deepLockSet) is carried out as sleep: mode=1 and the system domain stays on. After deepLockRel it is carried out as deep-sleep.
- R4: In sleep, a cluster with clock gating ends with clock off and isolation, reset and power untouched. A cluster with power gating ends fully off. The system domain stays on; mode=1.
- R5: A domain being powered down turns its clock off, then asserts isolation, then asserts reset, then removes power. On wake it restores power, waits for its pwrGood input, releases isolation, releases reset and enables the clock. Power is never off without isolation and reset asserted and the clock off.
- R6: Entry finishes the application core before the network core is touched, and in deep-sleep the network core before the system domain. Wake restores them in the reverse order.
- R7: In deep-sleep both clusters and the system domain end fully off regardless of the per-cluster choice; mode=2.
- R8: In deep-sleep only sources whose bit is set in AON_MASK (bits 3 to 7 by default) can wake; any other source leaves the outputs unchanged.
- R9: A source whose wakeEn bit is 0 is ignored in every mode.
- R10: When a wake completes, irqNet pulses for one cycle if a triggering source has wakeRoute=0, and irqApp pulses for one cycle if one has wakeRoute=1. Both pulse if the triggering sources are mixed.
- R11: After a completed entry, no domain output starts to restore until OSC_CYCLES clock cycles after the wake event.
- R12: A wake event during entry reverses the sequence from the current step without the oscillator wait.
- R13: wakeCause keeps a set bit for each source that triggered a wake until a 1 is written to that bit through causeClr.
- R14: A sleep request while busy=1 is ignored; mode and domain outputs do not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sleepReq | input | 1 | One-cycle sleep request strobe |
| reqDeep | input | 1 | Request targets deep-sleep |
| reqAppPg | input | 1 | Application core uses power gating in sleep (else clock gating) |
| reqNetPg | input | 1 | Network core uses power gating in sleep (else clock gating) |
| wakeLockHeld | input | 1 | Level: software holds the wakelock |
| deepLockSet | input | 1 | Strobe: take the deep lock |
| deepLockRel | input | 1 | Strobe: release the deep lock |
| wakeIn | input | N_SRC | Wakeup source levels |
| wakeEn | input | N_SRC | Per-source wake enable mask |
| wakeRoute | input | N_SRC | Per-source target: 0 network core, 1 application core |
| causeClr | input | N_SRC | Write-one-to-clear strobes for wakeCause |
| pwrGood | input | 3 | Per-domain supply-good indication |
| clkEn | output | 3 | Per-domain clock enable |
| isoEn | output | 3 | Per-domain isolation enable |
| rstAct | output | 3 | Per-domain reset asserted |
| pwrEn | output | 3 | Per-domain power switch enable |
| busy | output | 1 | Sequencer is not in its run state |
| mode | output | 2 | Current mode: 0 run, 1 sleep, 2 deep-sleep |
| wakeCause | output | N_SRC | Sticky record of triggering sources |
| irqNet | output | 1 | One-cycle wake interrupt to the network core |
| irqApp | output | 1 | One-cycle wake interrupt to the application core |

## Verification
The hardest situation to reach is a wake event landing partway through entry. This happens when a cluster has had isolation asserted but still has power, so that the reverse walk must start from a half-gated state. The bench reaches it by issuing a power-gated sleep request and raising two differently routed sources a few cycles later, well inside the entry sequence. It then checks that the block comes back within less than the oscillator time and with both interrupts. Per-step ordering is measured with a negative-edge monitor that timestamps every output transition. A supply-good model lags each power switch by a fixed number of cycles, so the isolation release can be checked against that lag.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

  localparam int NUM_DOM = 3;
  localparam int DOM_APP = 0;
  localparam int DOM_NET = 1;
  localparam int DOM_SYS = 2;

  localparam logic [1:0] TGT_ON  = 2'd0;
  localparam logic [1:0] TGT_CLK = 2'd1;
  localparam logic [1:0] TGT_OFF = 2'd2;

  localparam logic [1:0] MODE_RUN   = 2'd0;
  localparam logic [1:0] MODE_SLEEP = 2'd1;
  localparam logic [1:0] MODE_DEEP  = 2'd2;

  typedef enum logic [2:0] {
    S_IDLE, S_DOWN, S_SETTLE_D, S_ASLEEP, S_OSC, S_UP, S_SETTLE_U, S_DONE
  } seq_state_e;

  typedef struct packed {
    logic                      loadCfg;
    logic [NUM_DOM-1:0][1:0]   tgt;
    logic                      deep;
    logic                      stepDown;
    logic                      stepUp;
    logic [1:0]                dom;
    logic                      loadSettle;
    logic                      loadOsc;
    logic                      capture;
    logic                      fireIrq;
  } seq_ctl_t;

  typedef struct packed {
    logic [NUM_DOM-1:0] atTarget;
    logic [NUM_DOM-1:0] allOn;
    logic               cntZero;
    logic               wakeHit;
  } seq_sts_t;

endpackage

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl
  import pwr_seq_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                sleepReq,
  input  logic                reqDeep,
  input  logic                reqAppPg,
  input  logic                reqNetPg,
  input  logic                wakeLockHeld,
  input  logic                deepLockSet,
  input  logic                deepLockRel,
  input  logic [NUM_DOM-1:0]  pwrGood,
  input  seq_sts_t            sts,
  output seq_ctl_t            ctl,
  output logic                busy,
  output logic [1:0]          mode
);

  seq_state_e state, stateNext;
  logic [1:0] domIdx, domNext;
  logic [1:0] modeQ, modeNext;
  logic       deepLock;
  logic       deepOk;

  assign deepOk = reqDeep && !deepLock;

  always_comb begin
    ctl       = '0;
    ctl.dom   = domIdx;
    ctl.tgt[DOM_APP] = (deepOk || reqAppPg) ? TGT_OFF : TGT_CLK;
    ctl.tgt[DOM_NET] = (deepOk || reqNetPg) ? TGT_OFF : TGT_CLK;
    ctl.tgt[DOM_SYS] = deepOk ? TGT_OFF : TGT_ON;
    ctl.deep  = deepOk;
    stateNext = state;
    domNext   = domIdx;
    modeNext  = modeQ;
    unique case (state)
      S_IDLE: begin
        if (sleepReq && !wakeLockHeld) begin
          ctl.loadCfg = 1'b1;
          domNext     = 2'(DOM_APP);
          modeNext    = deepOk ? MODE_DEEP : MODE_SLEEP;
          stateNext   = S_DOWN;
        end
      end
      S_DOWN: begin
        if (sts.wakeHit) begin
          ctl.capture = 1'b1;
          domNext     = 2'(DOM_SYS);
          stateNext   = S_UP;
        end else if (sts.atTarget[domIdx]) begin
          if (domIdx == 2'(DOM_SYS)) stateNext = S_ASLEEP;
          else domNext = 2'(domIdx + 2'd1);
        end else begin
          ctl.stepDown   = 1'b1;
          ctl.loadSettle = 1'b1;
          stateNext      = S_SETTLE_D;
        end
      end
      S_SETTLE_D: begin
        if (sts.wakeHit) begin
          ctl.capture = 1'b1;
          domNext     = 2'(DOM_SYS);
          stateNext   = S_UP;
        end else if (sts.cntZero) begin
          stateNext = S_DOWN;
        end
      end
      S_ASLEEP: begin
        if (sts.wakeHit) begin
          ctl.capture = 1'b1;
          ctl.loadOsc = 1'b1;
          stateNext   = S_OSC;
        end
      end
      S_OSC: begin
        if (sts.cntZero) begin
          domNext   = 2'(DOM_SYS);
          stateNext = S_UP;
        end
      end
      S_UP: begin
        if (sts.allOn[domIdx]) begin
          if (domIdx == 2'(DOM_APP)) stateNext = S_DONE;
          else domNext = 2'(domIdx - 2'd1);
        end else begin
          ctl.stepUp     = 1'b1;
          ctl.loadSettle = 1'b1;
          stateNext      = S_SETTLE_U;
        end
      end
      S_SETTLE_U: begin
        if (sts.cntZero && pwrGood[domIdx]) stateNext = S_UP;
      end
      S_DONE: begin
        ctl.fireIrq = 1'b1;
        modeNext    = MODE_RUN;
        stateNext   = S_IDLE;
      end
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_IDLE;
      domIdx   <= 2'd0;
      modeQ    <= MODE_RUN;
      deepLock <= 1'b1;
    end else begin
      state  <= stateNext;
      domIdx <= domNext;
      modeQ  <= modeNext;
      if (deepLockSet)      deepLock <= 1'b1;
      else if (deepLockRel) deepLock <= 1'b0;
    end
  end

  assign busy = (state != S_IDLE);
  assign mode = modeQ;

  // R6: network core is not stepped down until the application core is done
  p_app_before_net_r6: assert property (@(posedge clk) disable iff (!rstN)
    ctl.stepDown && (domIdx == 2'(DOM_NET)) |-> sts.atTarget[DOM_APP]);

  // R6: application core is not restored until network and system are on
  p_net_before_app_r6: assert property (@(posedge clk) disable iff (!rstN)
    ctl.stepUp && (domIdx == 2'(DOM_APP)) |-> sts.allOn[DOM_NET] && sts.allOn[DOM_SYS]);

  // R3: deep-sleep is only entered with the deep lock released
  p_deep_needs_release_r3: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_DEEP) && ($past(mode) != MODE_DEEP) |-> !$past(deepLock));

  // R14: a request while sequencing leaves the mode alone
  p_busy_ignores_req_r14: assert property (@(posedge clk) disable iff (!rstN)
    busy && sleepReq && (state != S_DONE) |=> $stable(mode));

endmodule

// File: rtl/pwr_seq_dpath.sv
module pwr_seq_dpath
  import pwr_seq_pkg::*;
#(
  parameter int               N_SRC         = 8,
  parameter logic [N_SRC-1:0] AON_MASK      = 8'hF8,
  parameter int               SETTLE_CYCLES = 4,
  parameter int               OSC_CYCLES    = 1600
)(
  input  logic                clk,
  input  logic                rstN,
  input  seq_ctl_t            ctl,
  input  logic [N_SRC-1:0]    wakeIn,
  input  logic [N_SRC-1:0]    wakeEn,
  input  logic [N_SRC-1:0]    wakeRoute,
  input  logic [N_SRC-1:0]    causeClr,
  output seq_sts_t            sts,
  output logic [NUM_DOM-1:0]  clkEn,
  output logic [NUM_DOM-1:0]  isoEn,
  output logic [NUM_DOM-1:0]  rstAct,
  output logic [NUM_DOM-1:0]  pwrEn,
  output logic [N_SRC-1:0]    wakeCause,
  output logic                irqNet,
  output logic                irqApp
);

  localparam int CNT_MAX = (OSC_CYCLES > SETTLE_CYCLES) ? OSC_CYCLES : SETTLE_CYCLES;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  logic [NUM_DOM-1:0][1:0] tgtQ;
  logic                    deepQ;
  logic [CNT_W-1:0]        cnt;
  logic [N_SRC-1:0]        elig;
  logic [N_SRC-1:0]        causeQ;
  logic                    pendNet, pendApp;
  logic                    irqNetQ, irqAppQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tgtQ  <= '0;
      deepQ <= 1'b0;
    end else if (ctl.loadCfg) begin
      tgtQ  <= ctl.tgt;
      deepQ <= ctl.deep;
    end
  end

  for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
    logic cOn, iOn, rOn, pOn;
    logic selDown, selUp;
    assign selDown = ctl.stepDown && (ctl.dom == 2'(d));
    assign selUp   = ctl.stepUp   && (ctl.dom == 2'(d));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cOn <= 1'b1;
        iOn <= 1'b0;
        rOn <= 1'b0;
        pOn <= 1'b1;
      end else if (selDown) begin
        if (cOn)       cOn <= 1'b0;
        else if (!iOn) iOn <= 1'b1;
        else if (!rOn) rOn <= 1'b1;
        else           pOn <= 1'b0;
      end else if (selUp) begin
        if (!pOn)      pOn <= 1'b1;
        else if (iOn)  iOn <= 1'b0;
        else if (rOn)  rOn <= 1'b0;
        else           cOn <= 1'b1;
      end
    end

    always_comb begin
      unique case (tgtQ[d])
        TGT_ON:  sts.atTarget[d] = 1'b1;
        TGT_CLK: sts.atTarget[d] = !cOn;
        default: sts.atTarget[d] = !cOn && iOn && rOn && !pOn;
      endcase
    end
    assign sts.allOn[d] = cOn && !iOn && !rOn && pOn;

    assign clkEn[d]  = cOn;
    assign isoEn[d]  = iOn;
    assign rstAct[d] = rOn;
    assign pwrEn[d]  = pOn;

    // R5: a domain without power is always isolated, in reset and unclocked
    p_pwr_off_guarded_r5: assert property (@(posedge clk) disable iff (!rstN)
      !pOn |-> iOn && rOn && !cOn);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (ctl.loadOsc) begin
      cnt <= CNT_W'(OSC_CYCLES);
    end else if (ctl.loadSettle) begin
      cnt <= CNT_W'(SETTLE_CYCLES);
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end
  assign sts.cntZero = (cnt == '0);

  assign elig        = wakeIn & wakeEn & (deepQ ? AON_MASK : {N_SRC{1'b1}});
  assign sts.wakeHit = |elig;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      causeQ  <= '0;
      pendNet <= 1'b0;
      pendApp <= 1'b0;
      irqNetQ <= 1'b0;
      irqAppQ <= 1'b0;
    end else begin
      if (ctl.capture) begin
        causeQ  <= (causeQ & ~causeClr) | elig;
        pendNet <= |(elig & ~wakeRoute);
        pendApp <= |(elig & wakeRoute);
      end else begin
        causeQ  <= causeQ & ~causeClr;
      end
      irqNetQ <= ctl.fireIrq && pendNet;
      irqAppQ <= ctl.fireIrq && pendApp;
    end
  end

  assign wakeCause = causeQ;
  assign irqNet    = irqNetQ;
  assign irqApp    = irqAppQ;

  // R10: wake interrupts are single-cycle pulses
  p_irq_single_r10: assert property (@(posedge clk) disable iff (!rstN)
    irqNet || irqApp |=> !irqNet && !irqApp);

  // R8: a deep-sleep wake never records a source outside the always-on set
  p_deep_cause_aon_r8: assert property (@(posedge clk) disable iff (!rstN)
    deepQ && ctl.capture |=> ((wakeCause & ~$past(wakeCause)) & ~AON_MASK) == '0);

endmodule

// File: rtl/pwr_seq_top.sv
module pwr_seq_top
  import pwr_seq_pkg::*;
#(
  parameter int               N_SRC         = 8,
  parameter logic [N_SRC-1:0] AON_MASK      = 8'hF8,
  parameter int               SETTLE_CYCLES = 4,
  parameter int               OSC_CYCLES    = 1600
)(
  input  logic             clk,
  input  logic             rstN,
  input  logic             sleepReq,
  input  logic             reqDeep,
  input  logic             reqAppPg,
  input  logic             reqNetPg,
  input  logic             wakeLockHeld,
  input  logic             deepLockSet,
  input  logic             deepLockRel,
  input  logic [N_SRC-1:0] wakeIn,
  input  logic [N_SRC-1:0] wakeEn,
  input  logic [N_SRC-1:0] wakeRoute,
  input  logic [N_SRC-1:0] causeClr,
  input  logic [2:0]       pwrGood,
  output logic [2:0]       clkEn,
  output logic [2:0]       isoEn,
  output logic [2:0]       rstAct,
  output logic [2:0]       pwrEn,
  output logic             busy,
  output logic [1:0]       mode,
  output logic [N_SRC-1:0] wakeCause,
  output logic             irqNet,
  output logic             irqApp
);

  seq_ctl_t ctl;
  seq_sts_t sts;

  pwr_seq_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .sleepReq     (sleepReq),
    .reqDeep      (reqDeep),
    .reqAppPg     (reqAppPg),
    .reqNetPg     (reqNetPg),
    .wakeLockHeld (wakeLockHeld),
    .deepLockSet  (deepLockSet),
    .deepLockRel  (deepLockRel),
    .pwrGood      (pwrGood),
    .sts          (sts),
    .ctl          (ctl),
    .busy         (busy),
    .mode         (mode)
  );

  pwr_seq_dpath #(
    .N_SRC         (N_SRC),
    .AON_MASK      (AON_MASK),
    .SETTLE_CYCLES (SETTLE_CYCLES),
    .OSC_CYCLES    (OSC_CYCLES)
  ) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .wakeIn    (wakeIn),
    .wakeEn    (wakeEn),
    .wakeRoute (wakeRoute),
    .causeClr  (causeClr),
    .sts       (sts),
    .clkEn     (clkEn),
    .isoEn     (isoEn),
    .rstAct    (rstAct),
    .pwrEn     (pwrEn),
    .wakeCause (wakeCause),
    .irqNet    (irqNet),
    .irqApp    (irqApp)
  );

endmodule

// File: tb/tb_pwr_seq_top.sv
module tb_pwr_seq_top;

  localparam int N      = 8;
  localparam int SETTLE = 2;
  localparam int OSC    = 80;
  localparam int PG_DLY = 3;
  localparam logic [N-1:0] AON   = 8'hF8;
  localparam logic [N-1:0] ROUTE = 8'b1010_1100;
  localparam logic [N-1:0] MASKED_SRC = 8'h04;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sleepReq = 0, reqDeep = 0, reqAppPg = 0, reqNetPg = 0;
  logic wakeLockHeld = 0, deepLockSet = 0, deepLockRel = 0;
  logic [N-1:0] wakeIn = '0, wakeEn = ~MASKED_SRC, wakeRoute = ROUTE, causeClr = '0;
  logic [2:0] pwrGood = 3'b111;
  logic [2:0] clkEn, isoEn, rstAct, pwrEn;
  logic busy, irqNet, irqApp;
  logic [1:0] mode;
  logic [N-1:0] wakeCause;

  pwr_seq_top #(.N_SRC(N), .AON_MASK(AON), .SETTLE_CYCLES(SETTLE), .OSC_CYCLES(OSC)) dut (
    .clk(clk), .rstN(rstN), .sleepReq(sleepReq), .reqDeep(reqDeep),
    .reqAppPg(reqAppPg), .reqNetPg(reqNetPg), .wakeLockHeld(wakeLockHeld),
    .deepLockSet(deepLockSet), .deepLockRel(deepLockRel), .wakeIn(wakeIn),
    .wakeEn(wakeEn), .wakeRoute(wakeRoute), .causeClr(causeClr), .pwrGood(pwrGood),
    .clkEn(clkEn), .isoEn(isoEn), .rstAct(rstAct), .pwrEn(pwrEn), .busy(busy),
    .mode(mode), .wakeCause(wakeCause), .irqNet(irqNet), .irqApp(irqApp));

  always #5 clk = ~clk;

  int errors = 0, checks = 0;
  int cyc = 0;
  int nNet = 0, nApp = 0;
  int tClkOff[3], tIsoOn[3], tRstOn[3], tPwrOff[3];
  int tPwrOn[3], tIsoOff[3], tRstOff[3], tClkOn[3];
  int pgCnt[3];
  logic [2:0] pC = 3'b111, pI = 3'b000, pR = 3'b000, pP = 3'b111;
  bit lockReleased = 0;
  bit finished = 0;

  initial for (int d = 0; d < 3; d++) pgCnt[d] = PG_DLY;

  always @(negedge clk) begin
    cyc = cyc + 1;
    for (int d = 0; d < 3; d++) begin
      if (pC[d] && !clkEn[d] && tClkOff[d] < 0) tClkOff[d] = cyc;
      if (!pI[d] && isoEn[d] && tIsoOn[d] < 0) tIsoOn[d] = cyc;
      if (!pR[d] && rstAct[d] && tRstOn[d] < 0) tRstOn[d] = cyc;
      if (pP[d] && !pwrEn[d] && tPwrOff[d] < 0) tPwrOff[d] = cyc;
      if (!pP[d] && pwrEn[d] && tPwrOn[d] < 0) tPwrOn[d] = cyc;
      if (pI[d] && !isoEn[d] && tIsoOff[d] < 0) tIsoOff[d] = cyc;
      if (pR[d] && !rstAct[d] && tRstOff[d] < 0) tRstOff[d] = cyc;
      if (!pC[d] && clkEn[d] && tClkOn[d] < 0) tClkOn[d] = cyc;
      if (!pwrEn[d]) pgCnt[d] = 0;
      else if (pgCnt[d] < PG_DLY) pgCnt[d] = pgCnt[d] + 1;
      pwrGood[d] = (pgCnt[d] == PG_DLY);
    end
    if (irqNet) nNet = nNet + 1;
    if (irqApp) nApp = nApp + 1;
    pC = clkEn; pI = isoEn; pR = rstAct; pP = pwrEn;
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clearTimes();
    for (int d = 0; d < 3; d++) begin
      tClkOff[d] = -1; tIsoOn[d] = -1; tRstOn[d] = -1; tPwrOff[d] = -1;
      tPwrOn[d] = -1; tIsoOff[d] = -1; tRstOff[d] = -1; tClkOn[d] = -1;
    end
    nNet = 0; nApp = 0;
  endtask

  task automatic request(input bit dp, input bit aPg, input bit nPg);
    @(negedge clk);
    sleepReq = 1; reqDeep = dp; reqAppPg = aPg; reqNetPg = nPg;
    @(negedge clk);
    sleepReq = 0; reqDeep = 0; reqAppPg = 0; reqNetPg = 0;
  endtask

  task automatic pulseWake(input logic [N-1:0] srcs, output int when);
    @(negedge clk);
    wakeIn = srcs;
    when = cyc;
    @(negedge clk);
    wakeIn = '0;
  endtask

  task automatic waitIdle(output int when);
    when = -1;
    for (int i = 0; i < 800; i++) begin
      @(negedge clk);
      if (!busy) begin when = cyc; break; end
    end
    repeat (3) @(negedge clk);
  endtask

  function automatic int firstUp(input int d);
    return (tPwrOn[d] >= 0) ? tPwrOn[d] : tClkOn[d];
  endfunction

  task automatic clearCause(input logic [N-1:0] bits);
    @(negedge clk); causeClr = bits;
    @(negedge clk); causeClr = '0;
    @(negedge clk);
  endtask

  task automatic runFull(input bit dpReq, input bit aPg, input bit nPg, input int src);
    bit effDeep, aFull, nFull;
    logic [2:0] eClk, eIso, eRst, ePwr;
    int tW, tDone, tDummy, upMin;
    effDeep = dpReq && lockReleased;
    aFull = effDeep || aPg;
    nFull = effDeep || nPg;
    eClk = {!effDeep, 1'b0, 1'b0};
    eIso = {effDeep, nFull, aFull};
    eRst = eIso;
    ePwr = ~eIso;
    clearTimes();
    request(dpReq, aPg, nPg);
    repeat (150) @(negedge clk);
    chk("R4/R7 clkEn asleep", int'(clkEn), int'(eClk));
    chk("R4/R7 isoEn asleep", int'(isoEn), int'(eIso));
    chk("R4/R7 rstAct asleep", int'(rstAct), int'(eRst));
    chk("R4/R7 pwrEn asleep", int'(pwrEn), int'(ePwr));
    chk("R3 mode asleep", int'(mode), effDeep ? 2 : 1);
    chk("R14 busy asleep", int'(busy), 1);
    // R6 entry order
    if (aFull) chk("R6 app down before net", int'(tPwrOff[0] < tClkOff[1]), 1);
    else chk("R6 app down before net", int'(tClkOff[0] < tClkOff[1]), 1);
    if (effDeep) chk("R6 net down before sys", int'(tPwrOff[1] < tClkOff[2]), 1);
    if (nFull) chk("R5 entry step order", int'(tClkOff[1] < tIsoOn[1] && tIsoOn[1] < tRstOn[1]
                                               && tRstOn[1] < tPwrOff[1]), 1);
    // R14 request while asleep
    request(!dpReq, !aPg, !nPg);
    repeat (20) @(negedge clk);
    chk("R14 mode unchanged", int'(mode), effDeep ? 2 : 1);
    chk("R14 pwrEn unchanged", int'(pwrEn), int'(ePwr));
    // R9 masked source
    pulseWake(MASKED_SRC, tDummy);
    repeat (20) @(negedge clk);
    chk("R9 masked source ignored", int'(clkEn), int'(eClk));
    // R8 non-always-on source in deep
    if (effDeep) begin
      pulseWake(8'h01, tDummy);
      repeat (20) @(negedge clk);
      chk("R8 non-aon ignored pwrEn", int'(pwrEn), int'(ePwr));
      chk("R8 non-aon ignored busy", int'(busy), 1);
    end
    // wake
    pulseWake(N'(1) << src, tW);
    waitIdle(tDone);
    chk("R5 clkEn restored", int'(clkEn), 7);
    chk("R5 isoEn restored", int'(isoEn), 0);
    chk("R5 rstAct restored", int'(rstAct), 0);
    chk("R5 pwrEn restored", int'(pwrEn), 7);
    chk("R1 mode back to run", int'(mode), 0);
    chk("R10 irqApp count", nApp, ROUTE[src] ? 1 : 0);
    chk("R10 irqNet count", nNet, ROUTE[src] ? 0 : 1);
    chk("R13 cause recorded", int'(wakeCause), 1 << src);
    if (nFull) begin
      chk("R5 wake step order", int'(tPwrOn[1] < tIsoOff[1] && tIsoOff[1] < tRstOff[1]
                                    && tRstOff[1] < tClkOn[1]), 1);
      chk("R5 waits power good", int'(tIsoOff[1] - tPwrOn[1] >= PG_DLY), 1);
    end
    chk("R6 net up before app", int'(tClkOn[1] < firstUp(0)), 1);
    if (effDeep) chk("R6 sys up before net", int'(tClkOn[2] < firstUp(1)), 1);
    upMin = firstUp(1);
    if (effDeep) upMin = firstUp(2);
    chk("R11 oscillator wait", int'(upMin - tW >= OSC - 2), 1);
    clearCause(N'(1) << src);
    chk("R13 cause cleared", int'(wakeCause), 0);
  endtask

  initial begin
    int tW, tDone, tDummy;
    clearTimes();
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    chk("R1 clkEn", int'(clkEn), 7);
    chk("R1 isoEn", int'(isoEn), 0);
    chk("R1 rstAct", int'(rstAct), 0);
    chk("R1 pwrEn", int'(pwrEn), 7);
    chk("R1 busy", int'(busy), 0);
    chk("R1 mode", int'(mode), 0);
    chk("R1 cause", int'(wakeCause), 0);

    // R2 wakelock held
    wakeLockHeld = 1;
    request(1, 1, 1);
    repeat (20) @(negedge clk);
    chk("R2 busy with wakelock", int'(busy), 0);
    chk("R2 clkEn with wakelock", int'(clkEn), 7);
    wakeLockHeld = 0;

    // sleep sweep over gating choices (R3 deep lock still held on cfg 3)
    for (int c = 0; c < 4; c++) begin
      int s;
      s = (c == 0) ? 0 : (c == 1) ? 1 : (c == 2) ? 3 : 5;
      runFull(c == 3, c[0], c[1], s);
    end

    // deep runs after releasing the lock
    @(negedge clk); deepLockRel = 1; @(negedge clk); deepLockRel = 0;
    lockReleased = 1;
    runFull(1, 0, 0, 4);
    runFull(1, 1, 1, 7);
    runFull(1, 0, 1, 6);

    // R3 lock taken again
    @(negedge clk); deepLockSet = 1; @(negedge clk); deepLockSet = 0;
    lockReleased = 0;
    runFull(1, 0, 0, 3);

    // R12 wake during entry, two sources with mixed routes (R10)
    clearTimes();
    request(0, 1, 1);
    repeat (6) @(negedge clk);
    chk("R12 entry under way", int'(busy), 1);
    pulseWake(8'h09, tW);
    waitIdle(tDone);
    chk("R12 fast return", int'(tDone > 0 && tDone - tW < OSC), 1);
    chk("R12 clkEn restored", int'(clkEn), 7);
    chk("R12 pwrEn restored", int'(pwrEn), 7);
    chk("R12 isoEn restored", int'(isoEn), 0);
    chk("R10 mixed irqNet", nNet, 1);
    chk("R10 mixed irqApp", nApp, 1);
    chk("R13 both causes", int'(wakeCause), 9);
    clearCause(8'h01);
    chk("R13 partial clear", int'(wakeCause), 8);
    clearCause(8'h08);

    // R9 masked source does nothing while running either
    pulseWake(MASKED_SRC, tDummy);
    repeat (5) @(negedge clk);
    chk("R9 idle wake ignored", int'(busy), 0);

    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule